// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block holds the two system-management memory control bytes of a host bridge and turns them into the routing decisions that the memory fabric needs. The first byte carries an open bit, a lock bit and a global enable. The second byte carries a high-alias enable, a two-bit top-segment size code and a top-segment enable. From these bytes the block decides where the legacy SMRAM window goes for normal and for SMM accesses, and whether the high alias of that window is open. It also computes the size and base of the protected top-of-memory segment (TSEG). The base is the top of memory below 4 GiB minus the segment size.

A registered access filter classifies every request on the access port. The request carries an address, a direction and an SMM flag. The filter names the target: default decode, PCI space, RAM alias, or a black hole. A non-SMM read that hits the protected segment returns all ones, and a non-SMM write to it is dropped. A 16-bit size register supports a negotiated extended segment size. Software writes the all-ones query value, and the register answers with the configured number of MiB.

Top module: `smram_tseg_ctrl`

## Requirements
- R1: After reset the control byte reads 0x02, the extended byte reads 0x00, the size register reads 0xFFFF when EXT_TSEG_MB > 0 and 0x0000 otherwise, and every view output and tseg_mb are 0.
- R2: While unlocked, a write to the control byte (cfg_sel=0) changes only bits 6 (open), 4 (lock) and 3 (global enable); bits [2:0] stay 010. A write to the extended byte (cfg_sel=1) changes only bits 7 (high enable), [2:1] (size code) and 0 (segment enable); the other bits stay 0. When the result has the lock bit set, the open bit is cleared in the same update.
- R3: Once the lock bit reads 1, neither byte changes on any write until reset. The lock bit cannot be cleared by a write.
- R4: For normal accesses, the legacy range is RAM when open=1 and high=0, and otherwise PCI (nsmm_low_ram). The high alias is open only when open=1 and high=1 (nsmm_high_open).
- R5: For SMM accesses, the low alias is mapped when global=1 and high=0 (smm_low_ram), and the high alias when global=1 and high=1 (smm_high_ram). Neither is mapped when global=0.
- R6: The segment is active only when the segment enable and the global enable are both 1. Size codes 0, 1 and 2 give 1, 2 and 8 MiB, and code 3 gives EXT_TSEG_MB MiB. tseg_mb is 0 when the segment is inactive. tseg_base = lowmem_top - tseg_mb*2^20. View outputs follow a register change by one cycle.
- R7: The access filter answers one cycle after acc_valid with a target code: 0 pass, 1 PCI, 2 RAM, 3 hole. In the segment [tseg_base, lowmem_top), a non-SMM access gives 3, with acc_rd_ones=1 for a read and acc_wr_drop=1 for a write. An SMM access there gives 2.
- R8: The size register (cfg_sel=2) stores a written value. If the written value is 0xFFFF and EXT_TSEG_MB > 0, it stores EXT_TSEG_MB instead. With EXT_TSEG_MB = 0 it stays 0.
- R9: An access to the legacy range [0xA0000, 0xC0000) gives 2 when the normal view is RAM, or when it is an SMM access with the low alias mapped. Otherwise it gives 1. An access to [0xFEDA0000, 0xFEDC0000) gives 2 when the applicable alias is open, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 extended, 2 size, 3 none |
| cfg_wdata | input | XS_W | Write data (bytes use [7:0]) |
| ctrl_rd | output | 8 | Control byte |
| ext_rd | output | 8 | Extended byte |
| xsize_rd | output | XS_W | Extended size register |
| lowmem_top | input | ADDR_W | Top of memory below 4 GiB |
| nsmm_low_ram | output | 1 | Legacy range is RAM for normal accesses |
| nsmm_high_open | output | 1 | High alias open for normal accesses |
| smm_low_ram | output | 1 | Low alias mapped for SMM |
| smm_high_ram | output | 1 | High alias mapped for SMM |
| tseg_mb | output | XS_W | Active segment size in MiB |
| tseg_base | output | ADDR_W | Segment base address |
| acc_valid | input | 1 | Access request valid |
| acc_we | input | 1 | Access is a write |
| acc_smm | input | 1 | Access is in SMM |
| acc_addr | input | ADDR_W | Access address |
| acc_tgt_valid | output | 1 | Classification valid |
| acc_tgt | output | 2 | Target code |
| acc_rd_ones | output | 1 | Read returns all ones |
| acc_wr_drop | output | 1 | Write is discarded |

## Verification
The main instance is built with the default EXT_TSEG_MB of 16. This reaches the query answer and the fourth size code, which yields 16 MiB and moves the segment base to 0x7F000000 under a 2 GiB top of memory. A second instance with EXT_TSEG_MB of 0 shares all inputs. It shows that the size register stays zero, and that code 3 then leaves the segment inactive even with both enables set. Segment edges are probed one word inside and one word outside the segment bounds.

// File: rtl/smram_pkg.sv
package smram_pkg;
  typedef enum logic [1:0] {
    TGT_PASS = 2'd0,
    TGT_PCI  = 2'd1,
    TGT_RAM  = 2'd2,
    TGT_HOLE = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_EXT   = 2'd1,
    SEL_XSIZE = 2'd2,
    SEL_NONE  = 2'd3
  } sel_e;

  // control byte fields
  localparam int B_OPEN = 6;
  localparam int B_LOCK = 4;
  localparam int B_GEN  = 3;
  // extended byte fields
  localparam int B_HEN  = 7;
  localparam int B_SZHI = 2;
  localparam int B_SZLO = 1;
  localparam int B_TEN  = 0;

  localparam logic [7:0] CTRL_RST    = 8'h02;
  localparam logic [7:0] CTRL_WM     = 8'h58;
  localparam logic [7:0] CTRL_WM_LCK = 8'h00;
  localparam logic [7:0] EXT_RST     = 8'h00;
  localparam logic [7:0] EXT_WM      = 8'h87;
  localparam logic [7:0] EXT_WM_LCK  = 8'h00;
endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
  import smram_pkg::*;
#(
  parameter int XS_W        = 16,
  parameter int EXT_TSEG_MB = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [1:0]      sel,
  input  logic [XS_W-1:0] wdata,
  output logic [7:0]      ctrl_q,
  output logic [7:0]      ext_q,
  output logic [XS_W-1:0] xsize_q
);
  localparam logic [XS_W-1:0] QUERY  = '1;
  localparam logic [XS_W-1:0] EXT_V  = XS_W'(EXT_TSEG_MB);
  localparam logic [XS_W-1:0] XS_RST = (EXT_TSEG_MB > 0) ? QUERY : '0;

  sel_e       sel_e_w;
  logic       locked;
  logic [7:0] ctrl_wm, ext_wm;
  logic [7:0] ctrl_nxt, ext_nxt;

  assign sel_e_w = sel_e'(sel);
  assign locked  = ctrl_q[B_LOCK];
  assign ctrl_wm = locked ? CTRL_WM_LCK : CTRL_WM;
  assign ext_wm  = locked ? EXT_WM_LCK : EXT_WM;

  always_comb begin
    ctrl_nxt = (ctrl_q & ~ctrl_wm) | (wdata[7:0] & ctrl_wm);
    if (ctrl_nxt[B_LOCK]) ctrl_nxt[B_OPEN] = 1'b0;
    ext_nxt = (ext_q & ~ext_wm) | (wdata[7:0] & ext_wm);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      ext_q  <= EXT_RST;
    end else if (we) begin
      case (sel_e_w)
        SEL_CTRL: ctrl_q <= ctrl_nxt;
        SEL_EXT:  ext_q  <= ext_nxt;
        default: ;
      endcase
    end
  end

  generate
    if (EXT_TSEG_MB > 0) begin : g_xsize
      always_ff @(posedge clk) begin
        if (rst) xsize_q <= XS_RST;
        else if (we && sel_e_w == SEL_XSIZE)
          xsize_q <= (wdata == QUERY) ? EXT_V : wdata;
      end
    end else begin : g_noxsize
      assign xsize_q = '0;
    end
  endgenerate
endmodule

// File: rtl/smram_view_decode.sv
module smram_view_decode #(
  parameter int ADDR_W      = 32,
  parameter int XS_W        = 16,
  parameter int EXT_TSEG_MB = 16,
  parameter int MB_SHIFT    = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_open,
  input  logic              g_en,
  input  logic              h_en,
  input  logic              t_en,
  input  logic [1:0]        sz_code,
  input  logic [ADDR_W-1:0] lowtop,
  output logic              nlow_q,
  output logic              nhigh_q,
  output logic              slow_q,
  output logic              shigh_q,
  output logic              ton_q,
  output logic [XS_W-1:0]   mb_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] end_q
);
  localparam logic [XS_W-1:0] EXT_V = XS_W'(EXT_TSEG_MB);

  logic [XS_W-1:0]   mb_raw, mb_c;
  logic [ADDR_W-1:0] size_b;
  logic              on_c;

  always_comb begin
    case (sz_code)
      2'd0:    mb_raw = XS_W'(1);
      2'd1:    mb_raw = XS_W'(2);
      2'd2:    mb_raw = XS_W'(8);
      default: mb_raw = EXT_V;
    endcase
    on_c   = t_en && g_en && (mb_raw != '0);
    mb_c   = on_c ? mb_raw : '0;
    size_b = ADDR_W'(mb_c) << MB_SHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nlow_q  <= 1'b0;
      nhigh_q <= 1'b0;
      slow_q  <= 1'b0;
      shigh_q <= 1'b0;
      ton_q   <= 1'b0;
      mb_q    <= '0;
      base_q  <= '0;
      end_q   <= '0;
    end else begin
      nlow_q  <= d_open && !h_en;
      nhigh_q <= d_open && h_en;
      slow_q  <= g_en && !h_en;
      shigh_q <= g_en && h_en;
      ton_q   <= on_c;
      mb_q    <= mb_c;
      base_q  <= lowtop - size_b;
      end_q   <= lowtop;
    end
  end
endmodule

// File: rtl/smram_acc_filter.sv
module smram_acc_filter
  import smram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] LEG_BASE = 'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 'h0002_0000,
  parameter logic [ADDR_W-1:0] HI_BASE  = 'hFEDA_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nlow,
  input  logic              nhigh,
  input  logic              slow,
  input  logic              shigh,
  input  logic              ton,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] top,
  input  logic              valid,
  input  logic              we,
  input  logic              smm,
  input  logic [ADDR_W-1:0] addr,
  output logic              vld_q,
  output logic [1:0]        tgt_q,
  output logic              ones_q,
  output logic              drop_q
);
  localparam logic [ADDR_W-1:0] LEG_END = LEG_BASE + WIN_SIZE;
  localparam logic [ADDR_W-1:0] HI_END  = HI_BASE + WIN_SIZE;

  logic in_seg, in_leg, in_hi;
  tgt_e tgt_c;

  assign in_seg = ton && (addr >= base) && (addr < top);
  assign in_leg = (addr >= LEG_BASE) && (addr < LEG_END);
  assign in_hi  = (addr >= HI_BASE) && (addr < HI_END);

  always_comb begin
    if (in_seg)
      tgt_c = smm ? TGT_RAM : TGT_HOLE;
    else if (in_leg)
      tgt_c = (nlow || (smm && slow)) ? TGT_RAM : TGT_PCI;
    else if (in_hi)
      tgt_c = (nhigh || (smm && shigh)) ? TGT_RAM : TGT_PASS;
    else
      tgt_c = TGT_PASS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      tgt_q  <= TGT_PASS;
      ones_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      vld_q  <= valid;
      tgt_q  <= valid ? tgt_c : TGT_PASS;
      ones_q <= valid && !we && tgt_c == TGT_HOLE;
      drop_q <= valid && we && tgt_c == TGT_HOLE;
    end
  end
endmodule

// File: rtl/smram_tseg_ctrl.sv
module smram_tseg_ctrl
  import smram_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int XS_W        = 16,
  parameter int EXT_TSEG_MB = 16,
  parameter int MB_SHIFT    = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [XS_W-1:0]   cfg_wdata,
  output logic [7:0]        ctrl_rd,
  output logic [7:0]        ext_rd,
  output logic [XS_W-1:0]   xsize_rd,
  input  logic [ADDR_W-1:0] lowmem_top,
  output logic              nsmm_low_ram,
  output logic              nsmm_high_open,
  output logic              smm_low_ram,
  output logic              smm_high_ram,
  output logic [XS_W-1:0]   tseg_mb,
  output logic [ADDR_W-1:0] tseg_base,
  input  logic              acc_valid,
  input  logic              acc_we,
  input  logic              acc_smm,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_tgt_valid,
  output logic [1:0]        acc_tgt,
  output logic              acc_rd_ones,
  output logic              acc_wr_drop
);
  logic              seg_on;
  logic [ADDR_W-1:0] seg_end;

  smram_cfg_regs #(.XS_W(XS_W), .EXT_TSEG_MB(EXT_TSEG_MB)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .ctrl_q(ctrl_rd), .ext_q(ext_rd), .xsize_q(xsize_rd)
  );

  smram_view_decode #(
    .ADDR_W(ADDR_W), .XS_W(XS_W), .EXT_TSEG_MB(EXT_TSEG_MB), .MB_SHIFT(MB_SHIFT)
  ) u_view (
    .clk(clk), .rst(rst),
    .d_open(ctrl_rd[B_OPEN]), .g_en(ctrl_rd[B_GEN]),
    .h_en(ext_rd[B_HEN]), .t_en(ext_rd[B_TEN]), .sz_code(ext_rd[B_SZHI:B_SZLO]),
    .lowtop(lowmem_top),
    .nlow_q(nsmm_low_ram), .nhigh_q(nsmm_high_open),
    .slow_q(smm_low_ram), .shigh_q(smm_high_ram),
    .ton_q(seg_on), .mb_q(tseg_mb), .base_q(tseg_base), .end_q(seg_end)
  );

  smram_acc_filter #(.ADDR_W(ADDR_W)) u_filt (
    .clk(clk), .rst(rst),
    .nlow(nsmm_low_ram), .nhigh(nsmm_high_open),
    .slow(smm_low_ram), .shigh(smm_high_ram),
    .ton(seg_on), .base(tseg_base), .top(seg_end),
    .valid(acc_valid), .we(acc_we), .smm(acc_smm), .addr(acc_addr),
    .vld_q(acc_tgt_valid), .tgt_q(acc_tgt), .ones_q(acc_rd_ones), .drop_q(acc_wr_drop)
  );
endmodule

// File: rtl/smram_tseg_ctrl_chk.sv
module smram_tseg_ctrl_chk #(
  parameter int ADDR_W   = 32,
  parameter int XS_W     = 16,
  parameter int MB_SHIFT = 20
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        ctrl_rd,
  input logic [7:0]        ext_rd,
  input logic [ADDR_W-1:0] lowmem_top,
  input logic              nsmm_low_ram,
  input logic              nsmm_high_open,
  input logic              smm_low_ram,
  input logic              smm_high_ram,
  input logic [XS_W-1:0]   tseg_mb,
  input logic [ADDR_W-1:0] tseg_base,
  input logic [1:0]        acc_tgt,
  input logic              acc_rd_ones,
  input logic              acc_wr_drop
);
  logic [ADDR_W-1:0] size_b;
  assign size_b = ADDR_W'(tseg_mb) << MB_SHIFT;

  assert_lock_closes_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd[4] |-> !ctrl_rd[6]);

  assert_lock_freezes_R3: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd[4] |=> ($stable(ctrl_rd) && $stable(ext_rd)));

  assert_normal_excl_R4: assert property (@(posedge clk) disable iff (rst)
    nsmm_high_open |-> !nsmm_low_ram);

  assert_smm_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(smm_low_ram && smm_high_ram));

  assert_smm_off_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl_rd[3]) |-> (!smm_low_ram && !smm_high_ram));

  assert_seg_base_R6: assert property (@(posedge clk) disable iff (rst)
    (tseg_mb != '0) |-> (tseg_base == $past(lowmem_top) - size_b));

  assert_hole_rsp_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_rd_ones || acc_wr_drop) |-> (acc_tgt == 2'd3 && !(acc_rd_ones && acc_wr_drop)));
endmodule

bind smram_tseg_ctrl smram_tseg_ctrl_chk #(
  .ADDR_W(ADDR_W), .XS_W(XS_W), .MB_SHIFT(MB_SHIFT)
) u_chk (
  .clk(clk), .rst(rst), .ctrl_rd(ctrl_rd), .ext_rd(ext_rd),
  .lowmem_top(lowmem_top),
  .nsmm_low_ram(nsmm_low_ram), .nsmm_high_open(nsmm_high_open),
  .smm_low_ram(smm_low_ram), .smm_high_ram(smm_high_ram),
  .tseg_mb(tseg_mb), .tseg_base(tseg_base),
  .acc_tgt(acc_tgt), .acc_rd_ones(acc_rd_ones), .acc_wr_drop(acc_wr_drop)
);

// File: tb/smram_tseg_ctrl_bench.sv
`timescale 1ns/1ps
module smram_tseg_ctrl_bench;
  localparam int AW = 32;
  localparam int XW = 16;
  localparam logic [AW-1:0] TOP = 32'h8000_0000;

  typedef struct packed {
    logic [1:0]  sel;
    logic [15:0] wd;
    logic [7:0]  ctrl;
    logic [7:0]  ext;
    logic        nlow;
    logic        nhigh;
    logic        slow;
    logic        shigh;
    logic [15:0] mb;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'h0048, 8'h4A, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 16'd0},
    '{2'd1, 16'h0081, 8'h4A, 8'h81, 1'b0, 1'b1, 1'b0, 1'b1, 16'd1},
    '{2'd1, 16'h0003, 8'h4A, 8'h03, 1'b1, 1'b0, 1'b1, 1'b0, 16'd2},
    '{2'd1, 16'h0005, 8'h4A, 8'h05, 1'b1, 1'b0, 1'b1, 1'b0, 16'd8},
    '{2'd1, 16'h00FF, 8'h4A, 8'h87, 1'b0, 1'b1, 1'b0, 1'b1, 16'd16},
    '{2'd0, 16'h0008, 8'h0A, 8'h87, 1'b0, 1'b0, 1'b0, 1'b1, 16'd16},
    '{2'd0, 16'h0000, 8'h02, 8'h87, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0},
    '{2'd0, 16'h00FF, 8'h1A, 8'h87, 1'b0, 1'b0, 1'b0, 1'b1, 16'd16},
    '{2'd0, 16'h0000, 8'h1A, 8'h87, 1'b0, 1'b0, 1'b0, 1'b1, 16'd16},
    '{2'd1, 16'h0000, 8'h1A, 8'h87, 1'b0, 1'b0, 1'b0, 1'b1, 16'd16}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd3;
  logic [XW-1:0] cfg_wdata = '0;
  logic [AW-1:0] lowmem_top = TOP;
  logic acc_valid = 1'b0, acc_we = 1'b0, acc_smm = 1'b0;
  logic [AW-1:0] acc_addr = '0;

  logic [7:0] ctrl_rd, ext_rd;
  logic [XW-1:0] xsize_rd, tseg_mb, xsize_rd_b, tseg_mb_b;
  logic nlow, nhigh, slow, shigh, tv, ones, drop;
  logic [AW-1:0] tseg_base, tseg_base_b;
  logic [1:0] tgt;
  logic [7:0] c_b, e_b;
  logic nlow_b, nhigh_b, slow_b, shigh_b, tv_b, ones_b, drop_b;
  logic [1:0] tgt_b;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  smram_tseg_ctrl u_smram_tseg_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctrl_rd(ctrl_rd), .ext_rd(ext_rd), .xsize_rd(xsize_rd), .lowmem_top(lowmem_top),
    .nsmm_low_ram(nlow), .nsmm_high_open(nhigh), .smm_low_ram(slow), .smm_high_ram(shigh),
    .tseg_mb(tseg_mb), .tseg_base(tseg_base),
    .acc_valid(acc_valid), .acc_we(acc_we), .acc_smm(acc_smm), .acc_addr(acc_addr),
    .acc_tgt_valid(tv), .acc_tgt(tgt), .acc_rd_ones(ones), .acc_wr_drop(drop)
  );

  smram_tseg_ctrl #(.EXT_TSEG_MB(0)) u_smram_tseg_ctrl_noext (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctrl_rd(c_b), .ext_rd(e_b), .xsize_rd(xsize_rd_b), .lowmem_top(lowmem_top),
    .nsmm_low_ram(nlow_b), .nsmm_high_open(nhigh_b), .smm_low_ram(slow_b),
    .smm_high_ram(shigh_b), .tseg_mb(tseg_mb_b), .tseg_base(tseg_base_b),
    .acc_valid(acc_valid), .acc_we(acc_we), .acc_smm(acc_smm), .acc_addr(acc_addr),
    .acc_tgt_valid(tv_b), .acc_tgt(tgt_b), .acc_rd_ones(ones_b), .acc_wr_drop(drop_b)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
    repeat (2) @(negedge clk);
  endtask

  task automatic acc(input logic we, input logic smm, input logic [31:0] a,
                     input logic [1:0] et, input logic eo, input logic ed, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_we = we; acc_smm = smm; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
    chk({tag, " tgt"}, 32'(tgt), 32'(et));
    chk({tag, " ones"}, 32'(ones), 32'(eo));
    chk({tag, " drop"}, 32'(drop), 32'(ed));
    chk({tag, " valid"}, 32'(tv), 32'd1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", 32'(ctrl_rd), 32'h02);
    chk("R1 ext", 32'(ext_rd), 32'h00);
    chk("R1 xsize", 32'(xsize_rd), 32'hFFFF);
    chk("R1 xsize noext", 32'(xsize_rd_b), 32'h0);
    chk("R1 views", {28'd0, nlow, nhigh, slow, shigh}, 32'h0);
    chk("R1 mb", 32'(tseg_mb), 32'h0);

    // R8 size register
    wr(2'd2, 16'h1234);
    chk("R8 plain write", 32'(xsize_rd), 32'h1234);
    wr(2'd2, 16'hFFFF);
    chk("R8 query answer", 32'(xsize_rd), 32'd16);
    chk("R8 noext stays 0", 32'(xsize_rd_b), 32'h0);

    // table: R2 masks, R3 lock, R4/R5 views, R6 size and base
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].sel, VECS[i].wd);
      chk($sformatf("R2/R3 ctrl v%0d", i), 32'(ctrl_rd), 32'(VECS[i].ctrl));
      chk($sformatf("R2/R3 ext v%0d", i), 32'(ext_rd), 32'(VECS[i].ext));
      chk($sformatf("R4 normal view v%0d", i), {30'd0, nlow, nhigh},
          {30'd0, VECS[i].nlow, VECS[i].nhigh});
      chk($sformatf("R5 smm view v%0d", i), {30'd0, slow, shigh},
          {30'd0, VECS[i].slow, VECS[i].shigh});
      chk($sformatf("R6 mb v%0d", i), 32'(tseg_mb), 32'(VECS[i].mb));
      chk($sformatf("R6 base v%0d", i), tseg_base, TOP - (32'(VECS[i].mb) << 20));
      if (i == 4) chk("R6 code3 with no ext size", 32'(tseg_mb_b), 32'h0);
    end

    // R3 lock cannot be cleared; reset unlocks (R1)
    do_reset();
    chk("R1 ctrl after re-reset", 32'(ctrl_rd), 32'h02);

    // access filter: closed, global on, 8 MiB segment
    wr(2'd0, 16'h0008);
    wr(2'd1, 16'h0005);
    chk("R6 8MiB base", tseg_base, 32'h7F80_0000);
    acc(1'b0, 1'b0, 32'h7F80_0000, 2'd3, 1'b1, 1'b0, "R7 nsmm read seg low edge");
    acc(1'b1, 1'b0, 32'h7FFF_FFFC, 2'd3, 1'b0, 1'b1, "R7 nsmm write seg top word");
    acc(1'b0, 1'b1, 32'h7F80_0000, 2'd2, 1'b0, 1'b0, "R7 smm read seg");
    acc(1'b0, 1'b0, 32'h7F7F_FFFC, 2'd0, 1'b0, 1'b0, "R7 below seg");
    acc(1'b0, 1'b0, 32'h8000_0000, 2'd0, 1'b0, 1'b0, "R7 at top");
    acc(1'b0, 1'b0, 32'h000A_0000, 2'd1, 1'b0, 1'b0, "R9 nsmm legacy closed");
    acc(1'b0, 1'b1, 32'h000B_FFFC, 2'd2, 1'b0, 1'b0, "R9 smm legacy low alias");
    acc(1'b0, 1'b0, 32'h000C_0000, 2'd0, 1'b0, 1'b0, "R9 past legacy");
    acc(1'b0, 1'b0, 32'hFEDA_0000, 2'd0, 1'b0, 1'b0, "R9 nsmm high closed");
    // open with high enable
    wr(2'd1, 16'h0084);
    wr(2'd0, 16'h0048);
    acc(1'b0, 1'b0, 32'hFEDA_0000, 2'd2, 1'b0, 1'b0, "R9 nsmm high open");
    acc(1'b0, 1'b0, 32'h000A_0000, 2'd1, 1'b0, 1'b0, "R9 nsmm legacy hidden with high");
    acc(1'b1, 1'b0, 32'h7F80_0000, 2'd0, 1'b0, 1'b0, "R7 segment disabled");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule